// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a network controller. It walks a ring of descriptors in system memory. For each descriptor it reads the control word, the length word and the buffer address over a word-wide memory port whose responses can carry an error. When software owns the descriptor, the block stops. When the engine owns it, the block offers the buffer address and length to a downstream frame sender. It then waits for a completion that carries the frame status and a 64-bit timestamp, and closes the descriptor by writing back to memory.

Software sets the ring base address. It also sets the descriptor size: compact (4 words, 16 bytes) or extended (8 words, 32 bytes). It then pulses a start input. A descriptor that is still held by software suspends the walk until the next start. Any memory error halts the block for good, and only a reset clears that state. The ring base must be aligned to 16 bytes, and to 32 bytes in extended mode. Addresses are byte addresses, and descriptor word n sits at offset 4*n.

Top module: `txdesc_engine`

## Requirements
- R1: After reset, mem_req, frm_valid, tx_irq, st_suspended and st_fatal are 0, and st_err_kind is 0.
- R2: The first start after reset begins at cfg_ring_base. The block reads words 0, 1 and 2. It then holds frm_valid high, with frm_buf_addr equal to word 2 and frm_len equal to word 1 bits [12:0], until frm_ready is seen. All lengths up to 8191 pass through intact.
- R3: If word 0 bit 31 (ownership) reads 0, the block raises st_suspended, offers no frame and makes no further memory access. The next start clears st_suspended and reads the same descriptor again.
- R4: After a completion, word 0 is rewritten. Bit 31 becomes 0, bits [30:20] keep their fetched values, and bits [19:0] take cpl_status.
- R5: In extended mode, when word 0 bit 25 is set, the timestamp is written before word 0. The low 32 bits go to word 6 and then the high 32 bits go to word 7.
- R6: In compact mode, words 4 to 7 of a descriptor are never accessed, even when bit 25 is set.
- R7: After a descriptor is closed, the next one is read at the current address plus 16 (compact) or plus 32 (extended). If word 0 bit 21 (end of ring) was set, the next one is read at cfg_ring_base instead.
- R8: Closing a descriptor whose word 0 bit 30 is set raises tx_irq for exactly one cycle. Closing one with bit 30 clear raises no pulse.
- R9: A response with mem_err set stops all memory and frame activity and raises st_fatal. st_err_kind records the first error: 1 for a read, 2 for a write.
- R10: While st_fatal is 1, start pulses cause no memory access. Only reset clears st_fatal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| cfg_ext_desc | input | 1 | 1 selects 8-word descriptors, 0 selects 4-word descriptors |
| cfg_start | input | 1 | Start or resume pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the transfer |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| frm_valid | output | 1 | Frame buffer offered to the sender |
| frm_ready | input | 1 | Sender accepts the offered buffer |
| frm_buf_addr | output | AW | Buffer byte address |
| frm_len | output | LENW | Buffer length in bytes |
| cpl_valid | input | 1 | Frame completion strobe |
| cpl_status | input | 20 | Frame status to store in word 0 |
| cpl_tstamp | input | TSW | Timestamp captured for the frame |
| tx_irq | output | 1 | One-cycle completion interrupt |
| st_suspended | output | 1 | Walk stopped on a descriptor that software still owns |
| st_fatal | output | 1 | Halted by a bus error |
| st_err_kind | output | 2 | 0 none, 1 read error, 2 write error |

## Verification
The bench serves a frame of maximum length (8191) to catch a truncated length field. In extended mode it reads back the write order and finds the timestamp words ahead of word 0. A design that released ownership first would show word 0 earlier in that log. In compact mode with bit 25 set, it places sentinel words in the neighbouring descriptor and checks that they survive, so a design that ignored the size setting would overwrite them. It follows the end-of-ring bit to confirm that the next read returns to the base. It injects errors on a read and on a write, then issues a start. A design without a sticky halt would resume accesses, and one that lost the error kind would report the wrong code.

// File: rtl/txdesc_pkg.sv
// Shared definitions for the transmit descriptor walker: sequencer
// states, fault codes, word-0 bit positions and the close-word builder.
// Assumes 32-bit memory words and a 20-bit status field in word 0.
package txdesc_pkg;

    localparam int WORD_W    = 32;
    localparam int STAT_W    = 20;
    localparam int CTRL_LSB  = 20;
    localparam int CTRL_W    = WORD_W - CTRL_LSB;
    localparam int OWN_BIT   = 31;
    localparam int IOC_BIT   = 30;
    localparam int TSREQ_BIT = 25;
    localparam int EOR_BIT   = 21;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD0,
        S_RD1,
        S_RD2,
        S_OFFER,
        S_WAIT,
        S_WB6,
        S_WB7,
        S_WB0,
        S_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        FAULT_NONE  = 2'd0,
        FAULT_READ  = 2'd1,
        FAULT_WRITE = 2'd2
    } fault_kind_t;

    // Build the closing word 0: ownership cleared, control kept, status new.
    function automatic logic [WORD_W-1:0] close_word(
        input logic [CTRL_W-1:0] ctrl,
        input logic [STAT_W-1:0] stat
    );
        return {1'b0, ctrl[CTRL_W-2:0], stat};
    endfunction

endpackage

// File: rtl/txdesc_ptr.sv
// Current-descriptor pointer. It is loaded from the ring base on the
// first start after reset and, when a descriptor closes, it either
// advances by the selected stride or wraps to the base.
// Assumes load and step are never asserted together.
module txdesc_ptr #(
    parameter int AW       = 32,
    parameter int SMALL_WD = 4,
    parameter int LARGE_WD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          ext_mode,
    input  logic          load_base,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] ptr,
    output logic          primed
);

    localparam logic [AW-1:0] STRIDE_SMALL = AW'(SMALL_WD * 4);
    localparam logic [AW-1:0] STRIDE_LARGE = AW'(LARGE_WD * 4);

    logic [AW-1:0] stride;

    // Pick the byte stride from the descriptor-size selection.
    always_comb begin
        stride = ext_mode ? STRIDE_LARGE : STRIDE_SMALL;
    end

    // Hold the pointer; load, advance or wrap on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            primed <= 1'b0;
        end else if (load_base) begin
            ptr    <= ring_base;
            primed <= 1'b1;
        end else if (step) begin
            ptr    <= wrap ? ring_base : ptr + stride;
        end
    end

endmodule

// File: rtl/txdesc_fault.sv
// Fatal bus-error latch. It records the first error response and its
// direction, and only reset clears it.
// Assumes err_hit is a single-cycle qualifier of a completed transfer.
module txdesc_fault
    import txdesc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_hit,
    input  logic       err_is_write,
    output logic       fatal,
    output logic [1:0] kind
);

    // Latch the first error and keep it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fatal <= 1'b0;
            kind  <= FAULT_NONE;
        end else if (err_hit && !fatal) begin
            fatal <= 1'b1;
            kind  <= err_is_write ? FAULT_WRITE : FAULT_READ;
        end
    end

endmodule

// File: rtl/txdesc_seq.sv
// Descriptor sequencer: fetch words 0-2, check ownership, offer the
// buffer, wait for completion, then write back words 6 and 7 (when a
// timestamp is wanted in extended mode) followed by word 0.
// Assumes a memory port that completes a request when mem_ack is high
// and flags an error response with mem_err in the same cycle.
module txdesc_seq
    import txdesc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LENW = 13,
    parameter int TSW  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_mode,
    input  logic              fatal,
    input  logic              primed,
    input  logic [AW-1:0]     ptr,
    output logic              load_base,
    output logic              step,
    output logic              wrap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              err_hit,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic [AW-1:0]     frm_buf_addr,
    output logic [LENW-1:0]   frm_len,
    input  logic              cpl_valid,
    input  logic [STAT_W-1:0] cpl_status,
    input  logic [TSW-1:0]    cpl_tstamp,
    output logic              irq,
    output logic              suspended
);

    localparam int IOC_IDX  = IOC_BIT - CTRL_LSB;
    localparam int TS_IDX   = TSREQ_BIT - CTRL_LSB;
    localparam int EOR_IDX  = EOR_BIT - CTRL_LSB;
    localparam int TS_HI_LO = TSW - WORD_W;

    seq_state_t        state, nxt;
    logic [CTRL_W-1:0] ctrl_q;
    logic [LENW-1:0]   len_q;
    logic [AW-1:0]     buf_q;
    logic [STAT_W-1:0] stat_q;
    logic [TSW-1:0]    ts_q;
    logic              xfer_ok;
    logic              go;
    logic              ts_wanted;

    // Byte offset of descriptor word n.
    function automatic logic [AW-1:0] word_off(input int n);
        return AW'(n * 4);
    endfunction

    // Handshake and qualifier helpers.
    always_comb begin
        go        = (state == S_IDLE) && start && !fatal;
        xfer_ok   = mem_req && mem_ack && !mem_err;
        err_hit   = mem_req && mem_ack && mem_err;
        ts_wanted = ext_mode && ctrl_q[TS_IDX];
        load_base = go && !primed;
        step      = (state == S_WB0) && xfer_ok;
        wrap      = ctrl_q[EOR_IDX];
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:  if (go) nxt = S_RD0;
            S_RD0:   if (mem_ack) nxt = mem_err ? S_HALT :
                                    (mem_rdata[OWN_BIT] ? S_RD1 : S_IDLE);
            S_RD1:   if (mem_ack) nxt = mem_err ? S_HALT : S_RD2;
            S_RD2:   if (mem_ack) nxt = mem_err ? S_HALT : S_OFFER;
            S_OFFER: if (frm_ready) nxt = S_WAIT;
            S_WAIT:  if (cpl_valid) nxt = ts_wanted ? S_WB6 : S_WB0;
            S_WB6:   if (mem_ack) nxt = mem_err ? S_HALT : S_WB7;
            S_WB7:   if (mem_ack) nxt = mem_err ? S_HALT : S_WB0;
            S_WB0:   if (mem_ack) nxt = mem_err ? S_HALT : S_RD0;
            S_HALT:  nxt = S_HALT;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Memory request drive for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (state)
            S_RD0: mem_req = 1'b1;
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = ptr + word_off(1);
            end
            S_RD2: begin
                mem_req  = 1'b1;
                mem_addr = ptr + word_off(2);
            end
            S_WB6: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + word_off(6);
                mem_wdata = ts_q[WORD_W-1:0];
            end
            S_WB7: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + word_off(7);
                mem_wdata = ts_q[TSW-1:TS_HI_LO];
            end
            S_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = close_word(ctrl_q, stat_q);
            end
            default: ;
        endcase
    end

    // Capture descriptor fields as they are fetched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            len_q  <= '0;
            buf_q  <= '0;
        end else if (xfer_ok) begin
            if (state == S_RD0) ctrl_q <= mem_rdata[WORD_W-1:CTRL_LSB];
            if (state == S_RD1) len_q  <= mem_rdata[LENW-1:0];
            if (state == S_RD2) buf_q  <= mem_rdata[AW-1:0];
        end
    end

    // Capture completion status and timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ts_q   <= '0;
        end else if (state == S_WAIT && cpl_valid) begin
            stat_q <= cpl_status;
            ts_q   <= cpl_tstamp;
        end
    end

    // Completion interrupt pulse and suspension flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            suspended <= 1'b0;
        end else begin
            irq <= step && ctrl_q[IOC_IDX];
            if (state == S_RD0 && xfer_ok && !mem_rdata[OWN_BIT])
                suspended <= 1'b1;
            else if (go)
                suspended <= 1'b0;
        end
    end

    // Frame offer outputs.
    always_comb begin
        frm_valid    = (state == S_OFFER);
        frm_buf_addr = buf_q;
        frm_len      = len_q;
    end

endmodule

// File: rtl/txdesc_engine.sv
// Top of the transmit descriptor walker. It ties the sequencer to the
// pointer register and the fatal-error latch.
// Assumes the ring base is aligned to the selected descriptor size and
// that configuration inputs change only while the block is idle.
module txdesc_engine #(
    parameter int AW   = 32,
    parameter int LENW = 13,
    parameter int TSW  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cfg_ring_base,
    input  logic            cfg_ext_desc,
    input  logic            cfg_start,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_err,
    output logic            frm_valid,
    input  logic            frm_ready,
    output logic [AW-1:0]   frm_buf_addr,
    output logic [LENW-1:0] frm_len,
    input  logic            cpl_valid,
    input  logic [19:0]     cpl_status,
    input  logic [TSW-1:0]  cpl_tstamp,
    output logic            tx_irq,
    output logic            st_suspended,
    output logic            st_fatal,
    output logic [1:0]      st_err_kind
);

    logic [AW-1:0] desc_ptr;
    logic          primed;
    logic          load_base;
    logic          step;
    logic          wrap;
    logic          err_hit;

    txdesc_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (cfg_ring_base),
        .ext_mode  (cfg_ext_desc),
        .load_base (load_base),
        .step      (step),
        .wrap      (wrap),
        .ptr       (desc_ptr),
        .primed    (primed)
    );

    txdesc_fault u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_hit      (err_hit),
        .err_is_write (mem_we),
        .fatal        (st_fatal),
        .kind         (st_err_kind)
    );

    txdesc_seq #(.AW(AW), .LENW(LENW), .TSW(TSW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cfg_start),
        .ext_mode     (cfg_ext_desc),
        .fatal        (st_fatal),
        .primed       (primed),
        .ptr          (desc_ptr),
        .load_base    (load_base),
        .step         (step),
        .wrap         (wrap),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .mem_err      (mem_err),
        .err_hit      (err_hit),
        .frm_valid    (frm_valid),
        .frm_ready    (frm_ready),
        .frm_buf_addr (frm_buf_addr),
        .frm_len      (frm_len),
        .cpl_valid    (cpl_valid),
        .cpl_status   (cpl_status),
        .cpl_tstamp   (cpl_tstamp),
        .irq          (tx_irq),
        .suspended    (st_suspended)
    );

endmodule

// File: rtl/txdesc_engine_chk.sv
// Property checker for the transmit descriptor walker, attached by bind.
// Assumes the ring base is 16-byte aligned, so a word-0 write always
// has address bits [3:0] equal to zero.
module txdesc_engine_chk #(
    parameter int AW   = 32,
    parameter int LENW = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_ext_desc,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic [31:0]     mem_wdata,
    input logic            frm_valid,
    input logic            frm_ready,
    input logic [AW-1:0]   frm_buf_addr,
    input logic [LENW-1:0] frm_len,
    input logic            tx_irq,
    input logic            st_suspended,
    input logic            st_fatal,
    input logic [AW-1:0]   desc_ptr
);

    localparam logic [AW-1:0] SMALL_SPAN = AW'(16);

    // R2: an offered buffer stays put until it is accepted
    a_r2_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_ready |=> frm_valid && $stable(frm_buf_addr) && $stable(frm_len));

    // R3: a suspended walk makes no memory or frame activity
    a_r3_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_suspended |-> !mem_req && !frm_valid);

    // R4: a word-0 write always releases ownership
    a_r4_owner_released: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr[3:0] == 4'h0 |-> !mem_wdata[31]);

    // R6: compact descriptors are accessed only within their 16 bytes
    a_r6_compact_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !cfg_ext_desc |-> (mem_addr - desc_ptr) < SMALL_SPAN);

    // R8: the completion interrupt lasts a single cycle
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R9: a halted block makes no memory or frame activity
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_fatal |-> !mem_req && !frm_valid);

    // R10: the fatal flag stays set until reset
    a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_fatal |=> st_fatal);

endmodule

bind txdesc_engine txdesc_engine_chk #(.AW(AW), .LENW(LENW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ext_desc (cfg_ext_desc),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .frm_valid    (frm_valid),
    .frm_ready    (frm_ready),
    .frm_buf_addr (frm_buf_addr),
    .frm_len      (frm_len),
    .tx_irq       (tx_irq),
    .st_suspended (st_suspended),
    .st_fatal     (st_fatal),
    .desc_ptr     (desc_ptr)
);

// File: tb/sim_txdesc_engine.sv
// Directed bench for the transmit descriptor walker. A small memory
// model answers in the same cycle, and tasks play the frame sender.
module sim_txdesc_engine;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int LENW       = 13;
    localparam int TSW        = 64;
    localparam int WDOG       = 50000;

    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] IOC = 32'h4000_0000;
    localparam logic [31:0] TSR = 32'h0200_0000;
    localparam logic [31:0] EOR = 32'h0020_0000;
    localparam logic [31:0] KEEP = 32'h7FF0_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   cfg_ring_base = '0;
    logic            cfg_ext_desc = 1'b0;
    logic            cfg_start = 1'b0;
    logic            mem_req, mem_we, mem_ack, mem_err;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata, mem_rdata;
    logic            frm_valid;
    logic            frm_ready = 1'b0;
    logic [AW-1:0]   frm_buf_addr;
    logic [LENW-1:0] frm_len;
    logic            cpl_valid = 1'b0;
    logic [19:0]     cpl_status = '0;
    logic [TSW-1:0]  cpl_tstamp = '0;
    logic            tx_irq, st_suspended, st_fatal;
    logic [1:0]      st_err_kind;

    logic [31:0] mem [64];
    logic        err_on = 1'b0;
    logic        err_wr_only = 1'b0;
    logic [31:0] err_addr = '0;
    int          acc_cnt = 0;
    int          irq_cnt = 0;
    int          wcnt = 0;
    logic [7:0]  wlog [256];
    logic [31:0] last_rd = '0;
    int          n_tests = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_engine #(.AW(AW), .LENW(LENW), .TSW(TSW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base),
        .cfg_ext_desc(cfg_ext_desc), .cfg_start(cfg_start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_buf_addr(frm_buf_addr), .frm_len(frm_len),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_tstamp(cpl_tstamp), .tx_irq(tx_irq),
        .st_suspended(st_suspended), .st_fatal(st_fatal),
        .st_err_kind(st_err_kind)
    );

    // Memory model: answers in the same cycle, with an error injected on request.
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_err   = mem_req && err_on && (mem_addr == err_addr) && (!err_wr_only || mem_we);

    // Monitor: commit writes, log accesses, count interrupt pulses.
    always @(negedge clk) begin
        if (mem_req) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) begin
                if (!mem_err) mem[mem_addr[7:2]] <= mem_wdata;
                wlog[wcnt[7:0]] <= mem_addr[7:0];
                wcnt <= wcnt + 1;
            end else begin
                last_rd <= mem_addr;
            end
        end
        if (tx_irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        err_on = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    task automatic serve_frame(input logic [31:0] ea, input int el, input logic [19:0] st,
                               input logic [63:0] ts, input string req);
        int i = 0;
        while (!frm_valid && i < 200) begin
            @(negedge clk);
            i++;
        end
        check(frm_valid, req, {63'd0, frm_valid}, 64'd1);
        check(frm_buf_addr == ea, req, 64'(frm_buf_addr), 64'(ea));
        check(int'(frm_len) == el, req, 64'(frm_len), 64'(el));
        frm_ready = 1'b1;
        @(negedge clk);
        frm_ready = 1'b0;
        cpl_valid  = 1'b1;
        cpl_status = st;
        cpl_tstamp = ts;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // R1: outputs idle after reset.
    task automatic t_reset();
        do_reset();
        check(!mem_req && !frm_valid, "R1", {62'd0, mem_req, frm_valid}, 64'd0);
        check(!tx_irq && !st_suspended, "R1", {62'd0, tx_irq, st_suspended}, 64'd0);
        check(!st_fatal && st_err_kind == 2'd0, "R1", {61'd0, st_fatal, st_err_kind}, 64'd0);
    endtask

    // R2 R4 R6 R8 R3: compact ring, max length, timestamp request ignored.
    task automatic t_compact();
        logic [31:0] w0;
        int irq0, wc0;
        clear_mem();
        cfg_ext_desc = 1'b0;
        cfg_ring_base = 32'h0;
        w0 = OWN | IOC | TSR | 32'h0040_0000 | 32'h000A_BCDE;
        mem[0] = w0; mem[1] = 32'hFFFF_FFFF; mem[2] = 32'h1000_0000;
        mem[4] = 32'h0000_0000; mem[5] = 32'h5555_0005;
        mem[6] = 32'hA5A5_0006; mem[7] = 32'hA5A5_0007;
        irq0 = irq_cnt; wc0 = wcnt;
        pulse_start();
        serve_frame(32'h1000_0000, 8191, 20'h12345, 64'h1111_2222_3333_4444, "R2");
        repeat (10) @(negedge clk);
        check(mem[0] == ((w0 & KEEP) | 32'h12345), "R4", 64'(mem[0]), 64'((w0 & KEEP) | 32'h12345));
        check(mem[6] == 32'hA5A5_0006 && mem[7] == 32'hA5A5_0007, "R6", 64'(mem[7]), 64'hA5A5_0007);
        check(wcnt - wc0 == 1 && wlog[wc0[7:0]] == 8'h00, "R6", 64'(wcnt - wc0), 64'd1);
        check(irq_cnt - irq0 == 1, "R8", 64'(irq_cnt - irq0), 64'd1);
        check(st_suspended, "R3", {63'd0, st_suspended}, 64'd1);
        check(last_rd == 32'h10, "R7", 64'(last_rd), 64'h10);
    endtask

    // R3 R7 R8: resume on the same descriptor, no interrupt, end-of-ring wrap.
    task automatic t_resume_wrap();
        logic [31:0] w1;
        int irq0, acc0;
        acc0 = acc_cnt;
        repeat (4) @(negedge clk);
        check(acc_cnt == acc0, "R3", 64'(acc_cnt - acc0), 64'd0);
        w1 = OWN | EOR | 32'h0000_0077;
        mem[4] = w1; mem[5] = 32'h0000_0005; mem[6] = 32'h2222_0000;
        irq0 = irq_cnt;
        pulse_start();
        check(!st_suspended, "R3", {63'd0, st_suspended}, 64'd0);
        serve_frame(32'h2222_0000, 5, 20'h00ABC, 64'h0, "R3");
        repeat (10) @(negedge clk);
        check(mem[4] == ((w1 & KEEP) | 32'h00ABC), "R4", 64'(mem[4]), 64'((w1 & KEEP) | 32'h00ABC));
        check(irq_cnt == irq0, "R8", 64'(irq_cnt - irq0), 64'd0);
        check(last_rd == 32'h0 && st_suspended, "R7", 64'(last_rd), 64'h0);
    endtask

    // R5 R7: extended ring with timestamp, write order and stride.
    task automatic t_extended();
        int wc0;
        do_reset();
        clear_mem();
        cfg_ext_desc = 1'b1;
        cfg_ring_base = 32'h40;
        mem[16] = OWN | TSR; mem[17] = 32'd64; mem[18] = 32'h3000_0040;
        mem[22] = 32'hDEAD_0006; mem[23] = 32'hDEAD_0007; mem[24] = 32'h0;
        wc0 = wcnt;
        pulse_start();
        serve_frame(32'h3000_0040, 64, 20'h00001, 64'h89AB_CDEF_0123_4567, "R2");
        repeat (12) @(negedge clk);
        check(mem[22] == 32'h0123_4567, "R5", 64'(mem[22]), 64'h0123_4567);
        check(mem[23] == 32'h89AB_CDEF, "R5", 64'(mem[23]), 64'h89AB_CDEF);
        check(wcnt - wc0 == 3, "R5", 64'(wcnt - wc0), 64'd3);
        check(wlog[wc0[7:0]] == 8'h58 && wlog[8'(wc0 + 1)] == 8'h5C && wlog[8'(wc0 + 2)] == 8'h40,
              "R5", 64'(wlog[8'(wc0 + 2)]), 64'h40);
        check(mem[16] == 32'h0200_0001, "R4", 64'(mem[16]), 64'h0200_0001);
        check(last_rd == 32'h60, "R7", 64'(last_rd), 64'h60);
        cfg_ext_desc = 1'b0;
    endtask

    // R9 R10: read error halts, start ignored, reset clears.
    task automatic t_read_err();
        int acc0;
        do_reset();
        clear_mem();
        cfg_ring_base = 32'h0;
        mem[0] = OWN; mem[1] = 32'd10; mem[2] = 32'h4000_0000;
        err_on = 1'b1; err_wr_only = 1'b0; err_addr = 32'h4;
        pulse_start();
        repeat (5) @(negedge clk);
        check(st_fatal && st_err_kind == 2'd1, "R9", {61'd0, st_fatal, st_err_kind}, 64'h5);
        acc0 = acc_cnt;
        repeat (5) @(negedge clk);
        check(acc_cnt == acc0 && !frm_valid, "R9", 64'(acc_cnt - acc0), 64'd0);
        err_on = 1'b0;
        pulse_start();
        repeat (8) @(negedge clk);
        check(acc_cnt == acc0 && st_fatal, "R10", 64'(acc_cnt - acc0), 64'd0);
        do_reset();
        check(!st_fatal && st_err_kind == 2'd0, "R10", {61'd0, st_fatal, st_err_kind}, 64'd0);
    endtask

    // R9: write error during close records the write kind.
    task automatic t_write_err();
        clear_mem();
        cfg_ring_base = 32'h0;
        mem[0] = OWN | IOC; mem[1] = 32'd20; mem[2] = 32'h5000_0000;
        err_on = 1'b1; err_wr_only = 1'b1; err_addr = 32'h0;
        pulse_start();
        serve_frame(32'h5000_0000, 20, 20'h00002, 64'h0, "R9");
        repeat (6) @(negedge clk);
        check(st_fatal && st_err_kind == 2'd2, "R9", {61'd0, st_fatal, st_err_kind}, 64'h6);
        check(mem[0] == (OWN | IOC), "R9", 64'(mem[0]), 64'(OWN | IOC));
        err_on = 1'b0;
    endtask

    initial begin
        t_reset();
        t_compact();
        t_resume_wrap();
        t_extended();
        t_read_err();
        t_write_err();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule